// File: doc/BRIEF.md
# Event-Qualified Counter Capture Unit

This block keeps a bank of capture registers that take a snapshot of a free-running counter whenever chosen events fire. Sixteen raw event pulses arrive from outside, together with the current values of two 5-bit state variables (a low one and a high one). Each event is qualified by a 32-bit state mask and a one-bit selector that says which state variable the mask is indexed by. Only qualified events can trigger a capture.

The counter is presented as two 16-bit halves. In unified mode the halves form one 32-bit counter and each capture register loads as a whole. In split mode each capture register is two independent 16-bit registers, the low one fed by the low counter and the high one by the high counter, each with its own set of triggering events. A per-register control word decides which qualified events load which half.

Software configures and inspects the unit through a small byte-addressed register port with word and halfword access. Reads return data one cycle after the request.

Top module: `evq_capture_unit`

## Requirements
- R1: After reset every capture register, control word, state mask and the event selector register read as zero.
- R2: Event n is qualified in a cycle when its raw pulse is high and bit s of its state mask is set, where s is `state_hi` if bit n of the event selector register is 1 and `state_lo` if it is 0.
- R3: An event whose state mask is zero never loads any capture register, whatever the state values.
- R4: With `unify` high, control bit m (0..15) makes qualified event m load the whole capture register with {`cnt_hi`,`cnt_lo`}; control bits 31:16 have no effect.
- R5: With `unify` low, control bit m loads capture bits 15:0 from `cnt_lo` and control bit 16+m loads capture bits 31:16 from `cnt_hi`, each half leaving the other untouched.
- R6: A capture takes the counter value presented in the same cycle as the qualified event; several qualified events hitting one half in a cycle give a single load of that value.
- R7: When an event load and a software write hit the same capture half in one cycle, the event load wins; a write to the other half still takes effect.
- R8: Byte address map: capture n at 0x000+4n, control word n at 0x100+4n, state mask n at 0x200+4n, event selector (bit n = event n uses `state_hi`) at 0x300; word accesses (`bus_word`=1) read and write all 32 bits.
- R9: A halfword access (`bus_word`=0) with address bit 1 set addresses bits 31:16, otherwise bits 15:0; write data is taken from `bus_wdata[15:0]`, only the addressed half changes, and a halfword read returns that half in `bus_rdata[15:0]` with the upper bits zero.
- R10: A read request on `bus_re` raises `bus_rvalid` with the data on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unify | input | 1 | 1: one 32-bit counter; 0: two 16-bit halves |
| cnt_lo | input | 16 | Low counter half |
| cnt_hi | input | 16 | High counter half |
| ev_raw | input | 16 | Raw event pulses, one per event |
| state_lo | input | 5 | Current state of the low state machine |
| state_hi | input | 5 | Current state of the high state machine |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read request |
| bus_word | input | 1 | 1: 32-bit access; 0: 16-bit access |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid |

## Verification
The bench builds the unit with its default of sixteen capture registers, so every control word and mask address in the map is live and event-to-register fan-out is exercised at full width. Scenarios switch `unify` between captures on the same registers, pair the high-state selector with masks that match on only one state variable, use an all-zero mask at extreme states, and collide software writes with event loads in both modes.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int HALF_W  = 16;
  localparam int WORD_W  = 2 * HALF_W;
  localparam int NUM_EV  = 16;
  localparam int ST_W    = 5;
  localparam int NUM_ST  = 1 << ST_W;
  localparam int ADDR_W  = 10;
  localparam int IDX_W   = 4;

  typedef enum logic [1:0] {
    RG_CAP  = 2'd0,
    RG_CTRL = 2'd1,
    RG_MASK = 2'd2,
    RG_SEL  = 2'd3
  } region_e;
endpackage

// File: rtl/evq_event_qual.sv
module evq_event_qual
  import evq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_EV-1:0]              mask_we_lo,
  input  logic [NUM_EV-1:0]              mask_we_hi,
  input  logic                           sel_we_lo,
  input  logic [WORD_W-1:0]              wword,
  input  logic [NUM_EV-1:0]              ev_raw,
  input  logic [ST_W-1:0]                state_lo,
  input  logic [ST_W-1:0]                state_hi,
  output logic [NUM_EV-1:0][NUM_ST-1:0]  mask_q,
  output logic [NUM_EV-1:0]              sel_q,
  output logic [NUM_EV-1:0]              qev
);
  logic [NUM_EV-1:0][NUM_ST-1:0] mask_d;
  logic [NUM_EV-1:0]             sel_d;

  always_comb begin
    sel_d = sel_q;
    if (sel_we_lo) sel_d = wword[NUM_EV-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  for (genvar n = 0; n < NUM_EV; n++) begin : g_ev
    logic [ST_W-1:0] st;

    always_comb begin
      mask_d[n] = mask_q[n];
      if (mask_we_lo[n]) mask_d[n][HALF_W-1:0]      = wword[HALF_W-1:0];
      if (mask_we_hi[n]) mask_d[n][WORD_W-1:HALF_W] = wword[WORD_W-1:HALF_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[n] <= '0;
      else        mask_q[n] <= mask_d[n];
    end

    assign st     = sel_q[n] ? state_hi : state_lo;
    assign qev[n] = ev_raw[n] & mask_q[n][st];

    // R3: an all-zero mask blocks the event
    a_r3_zero_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[n] == '0) |-> !qev[n]);
  end

  // R2: no raw pulse, no qualified event
  a_r2_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_raw == '0) |-> (qev == '0));
endmodule

// File: rtl/evq_cap_slot.sv
module evq_cap_slot
  import evq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unify,
  input  logic [NUM_EV-1:0]  qev,
  input  logic [HALF_W-1:0]  cnt_lo,
  input  logic [HALF_W-1:0]  cnt_hi,
  input  logic               ctrl_we_lo,
  input  logic               ctrl_we_hi,
  input  logic               cap_we_lo,
  input  logic               cap_we_hi,
  input  logic [WORD_W-1:0]  wword,
  output logic [WORD_W-1:0]  ctrl_q,
  output logic [WORD_W-1:0]  cap_q
);
  logic [WORD_W-1:0] ctrl_d, cap_d;
  logic              hit_lo, hit_hi, ld_lo, ld_hi;

  assign hit_lo = |(ctrl_q[HALF_W-1:0] & qev);
  assign hit_hi = |(ctrl_q[WORD_W-1:HALF_W] & qev);
  assign ld_lo  = hit_lo;
  assign ld_hi  = unify ? hit_lo : hit_hi;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we_lo) ctrl_d[HALF_W-1:0]      = wword[HALF_W-1:0];
    if (ctrl_we_hi) ctrl_d[WORD_W-1:HALF_W] = wword[WORD_W-1:HALF_W];
  end

  always_comb begin
    cap_d = cap_q;
    if (ld_lo)          cap_d[HALF_W-1:0] = cnt_lo;
    else if (cap_we_lo) cap_d[HALF_W-1:0] = wword[HALF_W-1:0];
    if (ld_hi)          cap_d[WORD_W-1:HALF_W] = cnt_hi;
    else if (cap_we_hi) cap_d[WORD_W-1:HALF_W] = wword[WORD_W-1:HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cap_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cap_q  <= cap_d;
    end
  end

  // R4: unified load takes the full counter of that cycle
  a_r4_full_load: assert property (@(posedge clk) disable iff (!rst_n)
    (unify && (|(ctrl_q[HALF_W-1:0] & qev))) |=> (cap_q == $past({cnt_hi, cnt_lo})));

  // R5/R6: split low load takes the low counter of that cycle
  a_r5_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!unify && (|(ctrl_q[HALF_W-1:0] & qev))) |=> (cap_q[HALF_W-1:0] == $past(cnt_lo)));

  // R5: split high half holds without its own event or write
  a_r5_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!unify && !(|(ctrl_q[WORD_W-1:HALF_W] & qev)) && !cap_we_hi)
      |=> $stable(cap_q[WORD_W-1:HALF_W]));
endmodule

// File: rtl/evq_capture_unit.sv
module evq_capture_unit
  import evq_pkg::*;
#(
  parameter int NUM_CAP = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unify,
  input  logic [15:0]        cnt_lo,
  input  logic [15:0]        cnt_hi,
  input  logic [15:0]        ev_raw,
  input  logic [4:0]         state_lo,
  input  logic [4:0]         state_hi,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic               bus_word,
  input  logic [9:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid
);
  localparam int NCAP_EFF = (NUM_CAP > (1 << IDX_W)) ? (1 << IDX_W) : NUM_CAP;

  region_e              rg;
  logic [IDX_W-1:0]     idx;
  logic                 hsel, we_lo, we_hi;
  logic [WORD_W-1:0]    wword, rd_word, rdata_d;
  logic [NUM_EV-1:0]    mask_we_lo, mask_we_hi, sel_q, qev;
  logic                 sel_we_lo;
  logic [NUM_EV-1:0][NUM_ST-1:0] mask_q;
  logic [NCAP_EFF-1:0][WORD_W-1:0] ctrl_q, cap_q;

  assign rg    = region_e'(bus_addr[9:8]);
  assign idx   = bus_addr[5:2];
  assign hsel  = bus_addr[1];
  assign we_lo = bus_we & (bus_word | ~hsel);
  assign we_hi = bus_we & (bus_word | hsel);
  assign wword = {(bus_word ? bus_wdata[31:16] : bus_wdata[15:0]), bus_wdata[15:0]};

  always_comb begin
    mask_we_lo = '0;
    mask_we_hi = '0;
    if (rg == RG_MASK) begin
      mask_we_lo[idx] = we_lo;
      mask_we_hi[idx] = we_hi;
    end
  end
  assign sel_we_lo = we_lo & (rg == RG_SEL) & (idx == '0);

  evq_event_qual u_qual (
    .clk(clk), .rst_n(rst_n),
    .mask_we_lo(mask_we_lo), .mask_we_hi(mask_we_hi),
    .sel_we_lo(sel_we_lo), .wword(wword),
    .ev_raw(ev_raw), .state_lo(state_lo), .state_hi(state_hi),
    .mask_q(mask_q), .sel_q(sel_q), .qev(qev)
  );

  for (genvar i = 0; i < NCAP_EFF; i++) begin : g_cap
    logic hit_idx;
    assign hit_idx = (idx == IDX_W'(i));
    evq_cap_slot u_slot (
      .clk(clk), .rst_n(rst_n), .unify(unify), .qev(qev),
      .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
      .ctrl_we_lo(we_lo & hit_idx & (rg == RG_CTRL)),
      .ctrl_we_hi(we_hi & hit_idx & (rg == RG_CTRL)),
      .cap_we_lo (we_lo & hit_idx & (rg == RG_CAP)),
      .cap_we_hi (we_hi & hit_idx & (rg == RG_CAP)),
      .wword(wword), .ctrl_q(ctrl_q[i]), .cap_q(cap_q[i])
    );
  end

  always_comb begin
    rd_word = '0;
    unique case (rg)
      RG_CAP:  if (int'(idx) < NCAP_EFF) rd_word = cap_q[idx];
      RG_CTRL: if (int'(idx) < NCAP_EFF) rd_word = ctrl_q[idx];
      RG_MASK: rd_word = mask_q[idx];
      RG_SEL:  if (idx == '0) rd_word = {{(WORD_W-NUM_EV){1'b0}}, sel_q};
      default: rd_word = '0;
    endcase
    if (bus_word)  rdata_d = rd_word;
    else if (hsel) rdata_d = {{HALF_W{1'b0}}, rd_word[WORD_W-1:HALF_W]};
    else           rdata_d = {{HALF_W{1'b0}}, rd_word[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) bus_rdata <= rdata_d;
    end
  end

  // R10: read data one cycle after request
  a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_rvalid);
  a_r10_rvalid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> !bus_rvalid);
endmodule

// File: tb/evq_capture_unit_test.sv
module evq_capture_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unify = 1'b0;
  logic [15:0] cnt_lo = '0, cnt_hi = '0, ev_raw = '0;
  logic [4:0]  state_lo = '0, state_hi = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0, bus_word = 1'b1;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  evq_capture_unit uut (
    .clk(clk), .rst_n(rst_n), .unify(unify),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ev_raw(ev_raw),
    .state_lo(state_lo), .state_hi(state_hi),
    .bus_we(bus_we), .bus_re(bus_re), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  // monitor: pops expected reads as data returns
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R10 unexpected read data act=%h exp=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  // one cycle of stimulus: events, counter, states and an optional write
  task automatic step(input logic [15:0] raw, input logic [4:0] slo, input logic [4:0] shi,
                      input logic [15:0] lo, input logic [15:0] hi,
                      input logic we, input logic [9:0] addr, input logic [31:0] data,
                      input logic word);
    @(negedge clk);
    ev_raw = raw; state_lo = slo; state_hi = shi; cnt_lo = lo; cnt_hi = hi;
    bus_we = we; bus_addr = addr; bus_wdata = data; bus_word = word;
    @(negedge clk);
    ev_raw = '0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [9:0] addr, input logic [31:0] data, input logic word);
    step(16'h0, 5'd0, 5'd0, 16'h0, 16'h0, 1'b1, addr, data, word);
  endtask

  task automatic pulse(input logic [15:0] raw, input logic [4:0] slo, input logic [4:0] shi,
                       input logic [15:0] lo, input logic [15:0] hi);
    step(raw, slo, shi, lo, hi, 1'b0, 10'h0, 32'h0, 1'b1);
  endtask

  task automatic rd(input logic [9:0] addr, input logic word, input logic [31:0] e,
                    input string t);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = addr; bus_word = word;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(10'h000, 1'b1, 32'h0, "R1 cap0 reset");
    rd(10'h13C, 1'b1, 32'h0, "R1 ctrl15 reset");
    rd(10'h204, 1'b1, 32'h0, "R1 mask1 reset");
    rd(10'h300, 1'b1, 32'h0, "R1 selector reset");

    // R8/R9 masks and selector
    wr(10'h200, 32'h0000_0001, 1'b1);
    wr(10'h204, 32'h0000_0004, 1'b1);
    wr(10'h206, 32'h0000_0010, 1'b0);
    rd(10'h204, 1'b1, 32'h0010_0004, "R9 halfword write high half only");
    rd(10'h206, 1'b0, 32'h0000_0010, "R9 halfword read high");
    rd(10'h204, 1'b0, 32'h0000_0004, "R9 halfword read low");
    wr(10'h300, 32'h0000_0002, 1'b1);
    rd(10'h300, 1'b1, 32'h0000_0002, "R8 selector readback");

    // R4 unified
    unify = 1'b1;
    wr(10'h100, 32'h0002_0001, 1'b1);
    pulse(16'h0001, 5'd0, 5'd0, 16'h5678, 16'h1234);
    rd(10'h000, 1'b1, 32'h1234_5678, "R4 unified full capture");
    pulse(16'h0002, 5'd0, 5'd2, 16'h9999, 16'h9999);
    rd(10'h000, 1'b1, 32'h1234_5678, "R4 upper control bits ignored");

    // R5 split
    unify = 1'b0;
    wr(10'h104, 32'h0002_0001, 1'b1);
    rd(10'h104, 1'b1, 32'h0002_0001, "R8 control word readback");
    rd(10'h106, 1'b0, 32'h0000_0002, "R9 control high half read");
    pulse(16'h0001, 5'd0, 5'd0, 16'hAAAA, 16'hBBBB);
    rd(10'h004, 1'b1, 32'h0000_AAAA, "R5 split low half only");
    rd(10'h000, 1'b1, 32'h1234_AAAA, "R5 split low keeps old high");
    pulse(16'h0002, 5'd0, 5'd2, 16'h1111, 16'hCCCC);
    rd(10'h004, 1'b1, 32'hCCCC_AAAA, "R5 split high half from high state");
    // R2 state chosen by selector: state_lo matches mask but event uses high
    pulse(16'h0002, 5'd2, 5'd0, 16'h2222, 16'hDDDD);
    rd(10'h004, 1'b1, 32'hCCCC_AAAA, "R2 selector picks high state");
    rd(10'h006, 1'b0, 32'h0000_CCCC, "R9 capture high half read");

    // R3 zero mask
    wr(10'h108, 32'h0004_0004, 1'b1);
    pulse(16'h0004, 5'd0, 5'd0, 16'h7777, 16'h7777);
    rd(10'h008, 1'b1, 32'h0, "R3 zero mask state 0");
    pulse(16'h0004, 5'd31, 5'd31, 16'h7777, 16'h7777);
    rd(10'h008, 1'b1, 32'h0, "R3 zero mask state 31");

    // R6 several events one load
    wr(10'h10C, 32'h0000_0003, 1'b1);
    pulse(16'h0003, 5'd0, 5'd2, 16'h4242, 16'h0101);
    rd(10'h00C, 1'b1, 32'h0000_4242, "R6 two events single load");

    // R7 event beats write
    wr(10'h110, 32'h0000_0001, 1'b1);
    step(16'h0001, 5'd0, 5'd0, 16'h6060, 16'h7070, 1'b1, 10'h010, 32'h5555_6666, 1'b1);
    rd(10'h010, 1'b1, 32'h5555_6060, "R7 split event wins low, write lands high");
    wr(10'h010, 32'h0000_0123, 1'b0);
    rd(10'h010, 1'b1, 32'h5555_0123, "R9 halfword write capture low");
    unify = 1'b1;
    step(16'h0001, 5'd0, 5'd0, 16'h6060, 16'h7070, 1'b1, 10'h010, 32'hFFFF_FFFF, 1'b1);
    rd(10'h010, 1'b1, 32'h7070_6060, "R7 unified event wins both halves");
    unify = 1'b0;

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R10 missing read data act=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule